// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit sits next to a small 8-bit processor core and decides two things: whether the core should enter its interrupt sequence when the current instruction ends, and which service routine the core should then start. Hardware requests wait for an instruction boundary and are blocked by the core's mask bit. A software-interrupt instruction goes into the same sequence whether the mask is set or not. A reset request breaks off any activity at once.

The core stacks its registers and sets its mask bit without help from this unit. It reports the end of stacking with a strobe. Only then does the unit sample the pending requests and pick a winner. The winner is the source whose vector lies highest in memory. The unit then presents the two byte addresses of that vector on consecutive cycles, high byte first, each marked with a valid strobe. Request flags are level inputs that the service routines clear, and the unit never changes them.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `rst_req` is high, `irq_take` and `vec_valid` stay low from the next cycle on, and any sequence in progress is abandoned. In the cycle after `rst_req` is low in the reset state, the unit fetches the reset vector: `vec_addr` is 0x3FFE, then 0x3FFF on the next cycle.
- R2: `irq_take` is high only in a cycle in which `insn_done` is high. A request that is raised while an instruction is still running causes no take until that boundary.
- R3: Without a software interrupt, `irq_take` goes high at a boundary only when `i_mask` is 0 and at least one `hw_flag` bit has its matching `hw_en` bit set. Masked or disabled requests leave both `irq_take` and `vec_valid` low.
- R4: When `swi_req` is high at a boundary, `irq_take` goes high whatever the value of `i_mask`. The vector fetched is 0x3FFC/0x3FFD, and it beats any hardware request.
- R5: The winner is chosen in the cycle in which `stack_done` is high, from the requests that are enabled in that cycle. A request raised between the boundary and the end of stacking can win, and `i_mask` plays no part in this choice.
- R6: Hardware vector bases are fixed by bit position: bit 0 (external) 0x3FFA, bit 1 (carrier modulator) 0x3FF8, bit 2 (core timer) 0x3FF6. The lowest enabled pending bit has the highest vector and wins.
- R7: `vec_valid` is high for exactly two consecutive cycles, starting the cycle after `stack_done`. The first cycle carries the even high-byte address and the second carries that address plus one.
- R8: If no enabled request remains when stacking ends, the winner is chosen from the enabled requests that were latched at the boundary.
- R9: From a take until the low-byte cycle is over, `insn_done` causes no new take. `stack_done` has no effect outside the wait for stacking.
- R10: A pending flag whose enable bit is clear never wins the arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the unit's registers (puts it in the reset state) |
| rst_req | input | 1 | System reset request; aborts at once, vector fetched on release |
| swi_req | input | 1 | The instruction that is finishing is the software interrupt |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| stack_done | input | 1 | The core has finished stacking and set its mask |
| i_mask | input | 1 | The core's interrupt mask bit (1 = hardware requests blocked) |
| hw_flag | input | NUM_HW | Level request flags (bit 0 external, bit 1 carrier modulator, bit 2 core timer) |
| hw_en | input | NUM_HW | Per-source enable bits |
| irq_take | output | 1 | Enter the interrupt sequence at this boundary |
| vec_valid | output | 1 | `vec_addr` holds a vector byte address to fetch |
| vec_addr | output | AW | Vector fetch address, high byte then low byte |

## Verification
The main function is driven with random flag, enable, mask and software-interrupt patterns. The flags are changed again between the boundary and the end of stacking, which shows whether the winner is sampled at stacking or at the boundary. Directed cases cover several things: a request that appears before `insn_done`, which must be deferred; a masked request and a disabled request, which must both be ignored; a software interrupt taken while the mask is set; and all three hardware sources pending at once, where the external vector must win. Further directed cases check a winner that is cleared before stacking, which must fall back to the sources latched at the boundary, and a reset request that arrives in the middle of a vector fetch.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [2:0] {
        ST_RST   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_STACK = 3'd2,
        ST_VHI   = 3'd3,
        ST_VLO   = 3'd4
    } seq_state_e;

    // winner codes: 0 reset, 1 software interrupt, 2+i hardware source i
    localparam int CODE_RESET = 0;
    localparam int CODE_SWI   = 1;
    localparam int CODE_HW0   = 2;

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest set bit wins: it maps to the highest vector address
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen #(
    parameter int              AW      = 16,
    parameter int              CODE_W  = 3,
    parameter logic [AW-1:0]   VEC_TOP = 16'h3FFE
) (
    input  logic [CODE_W-1:0] code,
    input  logic              lo_byte,
    input  logic              en,
    output logic [AW-1:0]     addr
);
    logic [AW-1:0] base;

    always_comb begin
        base = VEC_TOP - (AW'(code) << 1);
        addr = en ? (base + AW'(lo_byte)) : '0;
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irqv_pkg::*;
#(
    parameter int            NUM_HW  = 3,
    parameter int            AW      = 16,
    parameter logic [AW-1:0] VEC_TOP = 16'h3FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              swi_req,
    input  logic              insn_done,
    input  logic              stack_done,
    input  logic              i_mask,
    input  logic [NUM_HW-1:0] hw_flag,
    input  logic [NUM_HW-1:0] hw_en,
    output logic              irq_take,
    output logic              vec_valid,
    output logic [AW-1:0]     vec_addr
);
    localparam int CODE_W = $clog2(NUM_HW + CODE_HW0);
    localparam int IW     = (NUM_HW > 1) ? $clog2(NUM_HW) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic              swi;
        logic [NUM_HW-1:0] bpend;
        logic [CODE_W-1:0] win;
    } arb_reg_t;

    arb_reg_t r_d, r_q;

    logic [NUM_HW-1:0] pend_now;
    logic              want;
    logic              now_any, bnd_any;
    logic [IW-1:0]     now_idx, bnd_idx;
    logic              idle_w;

    assign pend_now = hw_flag & hw_en;
    assign want     = swi_req | (~i_mask & (|pend_now));
    assign idle_w   = (r_q.st == ST_IDLE);
    assign irq_take = ~rst_req & idle_w & insn_done & want;

    irqv_prio #(.N(NUM_HW), .IW(IW)) prio_now_i (
        .req (pend_now),
        .any (now_any),
        .idx (now_idx)
    );

    irqv_prio #(.N(NUM_HW), .IW(IW)) prio_bnd_i (
        .req (r_q.bpend),
        .any (bnd_any),
        .idx (bnd_idx)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RST: begin
                r_d.win = CODE_W'(CODE_RESET);
                r_d.st  = ST_VHI;
            end
            ST_IDLE: begin
                if (irq_take) begin
                    r_d.st    = ST_STACK;
                    r_d.swi   = swi_req;
                    r_d.bpend = pend_now;
                end
            end
            ST_STACK: begin
                if (stack_done) begin
                    if (r_q.swi)
                        r_d.win = CODE_W'(CODE_SWI);
                    else if (now_any)
                        r_d.win = CODE_W'(CODE_HW0) + CODE_W'(now_idx);
                    else
                        r_d.win = CODE_W'(CODE_HW0) + CODE_W'(bnd_idx);
                    r_d.st = ST_VHI;
                end
            end
            ST_VHI:  r_d.st = ST_VLO;
            ST_VLO:  r_d.st = ST_IDLE;
            default: r_d.st = ST_RST;
        endcase
        if (rst_req) r_d.st = ST_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_RST;
            r_q.swi   <= 1'b0;
            r_q.bpend <= '0;
            r_q.win   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_valid = (r_q.st == ST_VHI) || (r_q.st == ST_VLO);

    irqv_vecgen #(.AW(AW), .CODE_W(CODE_W), .VEC_TOP(VEC_TOP)) vecgen_i (
        .code    (r_q.win),
        .lo_byte (r_q.st == ST_VLO),
        .en      (vec_valid),
        .addr    (vec_addr)
    );

    // bnd_any is kept for symmetry of the two arbiters
    logic unused_w;
    assign unused_w = bnd_any;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int            NUM_HW  = 3,
    parameter int            AW      = 16,
    parameter logic [AW-1:0] VEC_TOP = 16'h3FFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic              swi_req,
    input logic              insn_done,
    input logic              i_mask,
    input logic [NUM_HW-1:0] hw_flag,
    input logic [NUM_HW-1:0] hw_en,
    input logic              irq_take,
    input logic              vec_valid,
    input logic [AW-1:0]     vec_addr,
    input logic              seq_idle
);
    p_boundary_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> insn_done);

    p_hw_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !swi_req) |-> (!i_mask && ((hw_flag & hw_en) != '0)));

    p_swi_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && insn_done && swi_req && !rst_req) |-> irq_take);

    p_reset_no_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !irq_take);

    p_reset_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !vec_valid);

    p_pair_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_addr[0] && !rst_req) |=>
            (vec_valid && vec_addr == $past(vec_addr) + AW'(1)));

    p_pair_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_addr[0]) |=> !vec_valid);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_idle |-> !irq_take);

    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr <= VEC_TOP + AW'(1) &&
                       vec_addr >= VEC_TOP - AW'(2 * (NUM_HW + 1))));
endmodule

bind irq_vector_arbiter irqv_checker #(
    .NUM_HW(NUM_HW), .AW(AW), .VEC_TOP(VEC_TOP)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .swi_req   (swi_req),
    .insn_done (insn_done),
    .i_mask    (i_mask),
    .hw_flag   (hw_flag),
    .hw_en     (hw_en),
    .irq_take  (irq_take),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .seq_idle  (idle_w)
);

// File: tb/irq_vector_arbiter_tb_top.sv
module irq_vector_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, rst_req, swi_req, insn_done, stack_done, i_mask;
    logic [2:0]  hw_flag, hw_en;
    logic        irq_take, vec_valid;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_vector_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .swi_req(swi_req),
        .insn_done(insn_done), .stack_done(stack_done), .i_mask(i_mask),
        .hw_flag(hw_flag), .hw_en(hw_en), .irq_take(irq_take),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // next cycle, at a point well after the clock edge
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // highest vector among pending bits: lowest bit index wins
    function automatic logic [15:0] hw_vec(input logic [2:0] p);
        for (int i = 0; i < 3; i++)
            if (p[i]) return 16'h3FFA - 16'(2 * i);
        return 16'h0000;
    endfunction

    task automatic expect_pair(input logic [15:0] hi, input string req);
        #1;
        chk(vec_valid && vec_addr == hi, req, "high byte addr", {15'd0, vec_valid, vec_addr}, {16'd1, hi});
        cyc(); #1;
        chk(vec_valid && vec_addr == hi + 16'd1, req, "low byte addr", vec_addr, hi + 16'd1);
        cyc(); #1;
        chk(!vec_valid, "R7", "valid after pair", vec_valid, 0);
    endtask

    // finishes a taken sequence: optional busy cycles, new flags at stacking
    task automatic finish_seq(input logic [2:0] flags_at_stack, input int waits,
                              input logic [15:0] exp_hi, input string req);
        cyc();
        insn_done = 1'b0; swi_req = 1'b0; i_mask = 1'b1;
        for (int k = 0; k < waits; k++) begin
            insn_done = 1'b1;
            #1 chk(!irq_take, "R9", "take while busy", irq_take, 0);
            cyc();
            insn_done = 1'b0;
        end
        hw_flag = flags_at_stack; stack_done = 1'b1;
        cyc();
        stack_done = 1'b0;
        expect_pair(exp_hi, req);
    endtask

    // returns the take result at a boundary
    task automatic boundary(input bit s, input bit m, input logic [2:0] f,
                            input logic [2:0] e, input bit exp_take, input string req);
        swi_req = s; i_mask = m; hw_flag = f; hw_en = e; insn_done = 1'b1;
        #1 chk(irq_take == exp_take, req, "take at boundary", irq_take, exp_take);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] f, e, f2;
        bit m, s, t;
        logic [15:0] exp_hi;
        void'($urandom(32'd20240611));

        rst_n = 1'b0; rst_req = 1'b1; swi_req = 1'b0; insn_done = 1'b0;
        stack_done = 1'b0; i_mask = 1'b1; hw_flag = '0; hw_en = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc(); #1;
        chk(!vec_valid && !irq_take, "R1", "quiet while reset requested", {vec_valid, irq_take}, 0);
        insn_done = 1'b1; hw_flag = 3'b111; hw_en = 3'b111; i_mask = 1'b0;
        #1 chk(!irq_take, "R1", "no take during reset", irq_take, 0);
        insn_done = 1'b0; hw_flag = '0;
        rst_req = 1'b0;
        cyc();
        expect_pair(16'h3FFE, "R1");

        // deferral: request pending mid-instruction
        hw_flag = 3'b001; hw_en = 3'b001; i_mask = 1'b0; insn_done = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1 chk(!irq_take && !vec_valid, "R2", "deferred mid-instruction", irq_take, 0);
            cyc();
        end
        boundary(1'b0, 1'b0, 3'b001, 3'b001, 1'b1, "R2");
        finish_seq(3'b001, 1, 16'h3FFA, "R2");

        // masked request ignored
        boundary(1'b0, 1'b1, 3'b111, 3'b111, 1'b0, "R3");
        cyc(); insn_done = 1'b0;
        #1 chk(!vec_valid, "R3", "no vector for masked request", vec_valid, 0);
        // disabled request ignored
        boundary(1'b0, 1'b0, 3'b110, 3'b001, 1'b0, "R3");
        cyc(); insn_done = 1'b0;
        #1 chk(!vec_valid, "R3", "no vector for disabled request", vec_valid, 0);

        // software interrupt while masked, beats hardware
        boundary(1'b1, 1'b1, 3'b001, 3'b001, 1'b1, "R4");
        finish_seq(3'b001, 0, 16'h3FFC, "R4");

        // simultaneous requests: external wins
        boundary(1'b0, 1'b0, 3'b111, 3'b111, 1'b1, "R6");
        finish_seq(3'b111, 0, 16'h3FFA, "R6");
        boundary(1'b0, 1'b0, 3'b110, 3'b110, 1'b1, "R6");
        finish_seq(3'b110, 0, 16'h3FF8, "R6");

        // higher source raised during stacking wins
        boundary(1'b0, 1'b0, 3'b100, 3'b101, 1'b1, "R5");
        finish_seq(3'b101, 2, 16'h3FFA, "R5");

        // all flags cleared before stacking: boundary latch used
        boundary(1'b0, 1'b0, 3'b010, 3'b010, 1'b1, "R8");
        finish_seq(3'b000, 1, 16'h3FF8, "R8");

        // disabled flag never wins
        boundary(1'b0, 1'b0, 3'b100, 3'b100, 1'b1, "R10");
        finish_seq(3'b111, 0, 16'h3FF6, "R10");

        // stray stacking strobe while idle has no effect
        hw_flag = '0; insn_done = 1'b0; stack_done = 1'b1;
        cyc(); stack_done = 1'b0;
        #1 chk(!vec_valid, "R9", "stray stack strobe", vec_valid, 0);

        // reset in the middle of a vector fetch
        boundary(1'b0, 1'b0, 3'b001, 3'b001, 1'b1, "R1");
        cyc(); insn_done = 1'b0; stack_done = 1'b1;
        cyc(); stack_done = 1'b0;
        #1 chk(vec_valid && vec_addr == 16'h3FFA, "R1", "fetch before abort", vec_addr, 16'h3FFA);
        rst_req = 1'b1;
        cyc();
        #1 chk(!vec_valid, "R1", "abort on reset", vec_valid, 0);
        rst_req = 1'b0;
        cyc();
        expect_pair(16'h3FFE, "R1");

        // random patterns
        for (int it = 0; it < 300; it++) begin
            f = 3'($urandom); e = 3'($urandom); m = 1'($urandom);
            s = ($urandom % 4) == 0;
            hw_flag = f; hw_en = e; i_mask = m; swi_req = 1'b0; insn_done = 1'b0;
            #1 chk(!irq_take, "R2", "random mid-instruction", irq_take, 0);
            cyc();
            t = s | (!m && (f & e) != 0);
            boundary(s, m, f, e, t, s ? "R4" : "R3");
            if (t) begin
                f2 = 3'($urandom);
                if (s) exp_hi = 16'h3FFC;
                else if ((f2 & e) != 0) exp_hi = hw_vec(f2 & e);
                else exp_hi = hw_vec(f & e);
                finish_seq(f2, int'($urandom % 3), exp_hi, "R5");
            end else begin
                cyc(); insn_done = 1'b0; swi_req = 1'b0;
                #1 chk(!vec_valid, "R3", "random ignored request", vec_valid, 0);
                cyc();
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule